// File: doc/BRIEF.md
# Three-Tap Streaming FIR Filter with Cutset Pipelining

This block filters a stream of signed samples with three signed coefficients. It takes at most one sample per clock and produces one full-precision result per accepted sample. Each result is the weighted sum of the current sample and the two samples accepted before it. The coefficients come in on plain input ports. They are expected to stay steady while samples flow, and a change takes effect from the next accepted sample.

A single register stage cuts the signal graph between the two adders. The first stage forms the product-pair sum of the newest and previous sample, and it also forms the product of the oldest sample. These two values are registered side by side. The final adder then combines them in the following cycle. Because of this, the longest register-to-register path is one multiplier followed by one adder, where the unpipelined filter has one multiplier followed by two adders. The price is one clock of latency. While the final adder completes one result, the first stage is already working on the next sample.

Top module: `fir3_cutset`

## Requirements
- R1: For each accepted sample x(n), the result equals coef_a·x(n) + coef_b·x(n−1) + coef_c·x(n−2), where x(n−1) and x(n−2) are the two samples accepted before it. All values are two's-complement signed.
- R2: A sample is accepted on a rising clock edge where smp_valid_i is 1. res_valid_o is 1 and res_o carries that sample's result during the whole clock cycle that follows that edge.
- R3: res_o is 2·W+2 bits wide and signed. No combination of inputs overflows it. For example, with W=16, three products of −32768·−32768 give +3221225472.
- R4: Edges where smp_valid_i is 0 do not shift the sample history. The next accepted sample uses the same two earlier samples it would have used with no gap.
- R5: While rst_ni is 0, the sample history and the pipeline registers are cleared. After reset, res_valid_o is 0 and res_o is 0, and the first two samples use zero for the missing earlier samples.
- R6: Samples accepted on consecutive edges give results on consecutive cycles, one per cycle, with no stall.
- R7: After an edge where smp_valid_i is 0, res_valid_o is 0 for the following cycle.
- R8: While res_valid_o is 0, res_o keeps the value it last had.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample on smp_i is to be accepted this edge |
| smp_i | input | W | Signed input sample |
| coef_a_i | input | W | Signed weight of the newest sample |
| coef_b_i | input | W | Signed weight of the previous sample |
| coef_c_i | input | W | Signed weight of the sample before that |
| res_valid_o | output | 1 | res_o holds a fresh result |
| res_o | output | 2·W+2 | Signed full-precision filter result |

## Verification
In a continuous valid stream, the final addition of sample n and the first-stage products of sample n+1 happen in the same cycle. The history shift of the delay line happens in that cycle as well. Back-to-back streams of impulses and pseudo-random samples provoke this overlap. Every result is compared cycle by cycle with a weighted sum computed in the bench from its own copy of the sample history, so a result that picks up the wrong stage's partial sum, or a stale history, shows up as a mismatch. Gaps placed inside the stream check that the overlap does not advance history or refresh the output on idle edges.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  localparam int unsigned NUM_TAPS   = 3;
  localparam int unsigned GUARD_BITS = 2;
endpackage

// File: rtl/fir3_tap_line.sv
module fir3_tap_line #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [W-1:0]          din_i,
  output logic [DEPTH:0][W-1:0] tap_o
);
  logic [DEPTH-1:0][W-1:0] dly_q;

  assign tap_o[0] = din_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dly
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   dly_q[i] <= '0;
        else if (en_i) dly_q[i] <= din_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   dly_q[i] <= '0;
        else if (en_i) dly_q[i] <= dly_q[i-1];
      end
    end
    assign tap_o[i+1] = dly_q[i];
  end
endmodule

// File: rtl/fir3_mult.sv
module fir3_mult #(
  parameter int unsigned W = 16,
  localparam int unsigned PW = 2 * W
) (
  input  logic signed [W-1:0]  a_i,
  input  logic signed [W-1:0]  b_i,
  output logic signed [PW-1:0] p_o
);
  logic signed [PW-1:0] a_ext, b_ext;
  assign a_ext = PW'(a_i);
  assign b_ext = PW'(b_i);
  assign p_o   = a_ext * b_ext;
endmodule

// File: rtl/fir3_cutset.sv
module fir3_cutset
  import fir3_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned PW    = 2 * W,
  localparam int unsigned ACC_W = PW + GUARD_BITS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_valid_i,
  input  logic signed [W-1:0]     smp_i,
  input  logic signed [W-1:0]     coef_a_i,
  input  logic signed [W-1:0]     coef_b_i,
  input  logic signed [W-1:0]     coef_c_i,
  output logic                    res_valid_o,
  output logic signed [ACC_W-1:0] res_o
);
  logic [NUM_TAPS-1:0][W-1:0]  tap;
  logic [NUM_TAPS-1:0][W-1:0]  coef;
  logic [NUM_TAPS-1:0][PW-1:0] prod;

  assign coef = {coef_c_i, coef_b_i, coef_a_i};

  fir3_tap_line #(.W(W), .DEPTH(NUM_TAPS - 1)) i_tap_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (smp_valid_i),
    .din_i  (smp_i),
    .tap_o  (tap)
  );

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_mul
    fir3_mult #(.W(W)) i_mult (
      .a_i ($signed(tap[t])),
      .b_i ($signed(coef[t])),
      .p_o (prod[t])
    );
  end

  // Stage 1: first adder plus the oldest product; the cutset lies below it.
  logic signed [ACC_W-1:0] pair_sum_d, pair_sum_q;
  logic signed [PW-1:0]    old_prod_q;
  logic                    vld_q;

  assign pair_sum_d = ACC_W'($signed(prod[0])) + ACC_W'($signed(prod[1]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_sum_q <= '0;
      old_prod_q <= '0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= smp_valid_i;
      if (smp_valid_i) begin
        pair_sum_q <= pair_sum_d;
        old_prod_q <= $signed(prod[NUM_TAPS-1]);
      end
    end
  end

  // Stage 2: final adder, fed only from cutset registers.
  assign res_o       = pair_sum_q + ACC_W'(old_prod_q);
  assign res_valid_o = vld_q;
endmodule

// File: rtl/fir3_cutset_chk.sv
module fir3_cutset_chk #(
  parameter int unsigned W = 16,
  localparam int unsigned ACC_W = 2 * W + 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    smp_valid_i,
  input logic signed [W-1:0]     smp_i,
  input logic signed [W-1:0]     coef_a_i,
  input logic signed [W-1:0]     coef_b_i,
  input logic signed [W-1:0]     coef_c_i,
  input logic                    res_valid_o,
  input logic signed [ACC_W-1:0] res_o
);
  logic signed [W-1:0]     h1_q, h2_q;
  logic signed [ACC_W-1:0] exp_d, exp_q;

  assign exp_d = ACC_W'(coef_a_i) * ACC_W'(smp_i)
               + ACC_W'(coef_b_i) * ACC_W'(h1_q)
               + ACC_W'(coef_c_i) * ACC_W'(h2_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h1_q  <= '0;
      h2_q  <= '0;
      exp_q <= '0;
    end else if (smp_valid_i) begin
      h1_q  <= smp_i;
      h2_q  <= h1_q;
      exp_q <= exp_d;
    end
  end

  assert_result_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> res_o == exp_q);

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> res_valid_o);

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !res_valid_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> $stable(res_o));
endmodule

bind fir3_cutset fir3_cutset_chk #(.W(W)) i_fir3_cutset_chk (.*);

// File: tb/test_fir3_cutset.sv
module test_fir3_cutset;
  localparam int unsigned W = 16;
  localparam int unsigned ACC_W = 2 * W + 2;

  logic                    clk = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    smp_valid_i = 1'b0;
  logic signed [W-1:0]     smp_i = '0;
  logic signed [W-1:0]     coef_a_i = '0, coef_b_i = '0, coef_c_i = '0;
  logic                    res_valid_o;
  logic signed [ACC_W-1:0] res_o;

  int n_chk = 0, n_fail = 0;
  longint h1 = 0, h2 = 0, last_res = 0;

  always #4 clk = ~clk;

  fir3_cutset #(.W(W)) i_fir3_cutset (
    .clk_i(clk), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
    .coef_a_i(coef_a_i), .coef_b_i(coef_b_i), .coef_c_i(coef_c_i),
    .res_valid_o(res_valid_o), .res_o(res_o)
  );

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_coef(int a, int b, int c);
    coef_a_i = W'(a); coef_b_i = W'(b); coef_c_i = W'(c);
  endtask

  // One clock: drive at negedge, sample at the following negedge.
  task automatic step(bit vld, int x, string req);
    longint exp;
    smp_valid_i = vld;
    smp_i = W'(x);
    exp = longint'(coef_a_i) * longint'(smp_i) + longint'(coef_b_i) * h1
        + longint'(coef_c_i) * h2;
    @(posedge clk);
    @(negedge clk);
    if (vld) begin
      h2 = h1; h1 = longint'(smp_i);
      check({req, " valid"}, longint'(res_valid_o), 1);
      check({req, " value"}, longint'(res_o), exp);
      last_res = exp;
    end else begin
      check("R7 idle valid", longint'(res_valid_o), 0);
      check("R8 held value", longint'(res_o), last_res);
    end
  endtask

  task automatic do_reset();
    smp_valid_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 reset valid", longint'(res_valid_o), 0);
    check("R5 reset value", longint'(res_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    h1 = 0; h2 = 0; last_res = 0;
  endtask

  task automatic t_impulse();
    do_reset();
    set_coef(3, -5, 7);
    step(1, 1, "R1 impulse");
    step(1, 0, "R1 impulse");
    step(1, 0, "R1 impulse");
    step(1, 0, "R6 impulse tail");
    check("R1 third tap", last_res, 0);
  endtask

  task automatic t_zero_history();
    do_reset();
    set_coef(11, 13, 17);
    step(1, 10, "R5 first sample");
    check("R5 first uses zero history", last_res, 110);
    step(1, -4, "R5 second sample");
  endtask

  task automatic t_gaps();
    do_reset();
    set_coef(-2, 9, 4);
    step(1, 5, "R4 pre");
    step(1, -6, "R4 pre");
    step(0, 123, "R7");
    step(0, -77, "R7");
    step(1, 2, "R4 after gap");
    check("R4 history kept", last_res, -4 - 54 + 20);
    step(0, 0, "R7");
    step(1, 8, "R4 after gap");
  endtask

  task automatic t_extremes();
    do_reset();
    set_coef(-32768, -32768, -32768);
    step(1, -32768, "R3 extreme");
    step(1, -32768, "R3 extreme");
    step(1, -32768, "R3 extreme");
    check("R3 max positive", last_res, 64'sd3221225472);
    set_coef(32767, 32767, 32767);
    step(1, -32768, "R3 extreme neg");
    step(1, -32768, "R3 extreme neg");
    step(1, -32768, "R3 extreme neg");
    check("R3 max negative", last_res, -64'sd3221127168);
  endtask

  task automatic t_stream();
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    set_coef(1234, -31000, 777);
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 37 == 36) step(0, int'(lfsr), "R7");
      else              step(1, int'($signed(lfsr)), "R6 stream");
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_impulse();
    t_zero_history();
    t_gaps();
    t_extremes();
    t_stream();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule